// File: doc/BRIEF.md
# Low Pin Count Bus Cycle Monitor

This block watches a Low Pin Count bus without driving it. It samples the active-low frame strobe and the 4-bit LAD lines on the rising edge of the bus clock. It follows each host-initiated memory or I/O transfer through its fields: start, cycle kind and direction, address, first turnaround, sync, data, and closing turnaround. When a transfer completes, it reports the decoded transfer on a single-clock strobe.

The monitor also reports two kinds of fault as pulses. A turnaround nibble other than all-ones gives a warning, and decoding goes on. An unknown sync code gives an error, and the monitor drops back to idle. The frame strobe may fall again at any time. This aborts the transfer in progress and opens a new start field, so transfers can follow each other with no idle clock between them.

Top module: `lpc_cycle_mon`

## Requirements
- R1: While reset is low at a clock edge, every output goes to zero: the strobes, the address, the data, the kind, the direction and the warning fields.
- R2: The start nibble is the LAD value sampled on the last clock on which the frame strobe is low. A transfer is decoded only if that nibble is 0000. Any other final start nibble makes the monitor ignore the rest of the transfer.
- R3: The LAD nibble on the first clock with the frame strobe high is the kind/direction nibble. Bits [3:2] = 00 select I/O and 01 select memory. Bit 1 = 1 means write and 0 means read. If bit 3 is 1, the transfer is ignored.
- R4: A memory transfer carries 8 address nibbles, most significant first, forming a 32-bit address.
- R5: An I/O transfer carries 4 address nibbles, most significant first. The upper 16 bits of the reported address are zero.
- R6: Each turnaround field lasts 2 clocks and should read 1111. Any other nibble produces a one-clock tar_warn pulse on the clock after it is sampled. The pulse carries the nibble, the clock index within the field (0 or 1) and which turnaround it was (0 = first, 1 = second). Decoding is not affected.
- R7: A sync nibble of 0000 moves on to the data field. Sync nibbles 0101 and 0110 hold the monitor in sync for any number of clocks.
- R8: Any other sync nibble produces a one-clock sync_err pulse and returns the monitor to idle. No cycle_valid is issued for that transfer.
- R9: The data field lasts 2 clocks, least significant nibble first. The first nibble forms bits [3:0] of the byte and the second forms bits [7:4].
- R10: cycle_valid is high for exactly one clock, starting on the clock after the last turnaround nibble is sampled. The reported address, data, kind and direction stay unchanged until the next completed transfer.
- R11: A new transfer may begin with the frame strobe low on the clock right after the last turnaround nibble. That transfer is decoded in full.
- R12: If the frame strobe goes low during address, turnaround, sync or data, the current transfer is abandoned and a new start field begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all sampling on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_n | input | 1 | Active-low frame strobe observed on the bus |
| lad | input | 4 | Observed LAD nibble |
| cycle_valid | output | 1 | One-clock strobe: a transfer completed |
| cycle_is_mem | output | 1 | 1 = memory transfer, 0 = I/O transfer |
| cycle_write | output | 1 | 1 = write, 0 = read |
| cycle_addr | output | 32 | Assembled address |
| cycle_data | output | 8 | Assembled data byte |
| tar_warn | output | 1 | One-clock strobe: turnaround nibble was not 1111 |
| tar_warn_nib | output | 4 | Nibble seen in the faulty turnaround clock |
| tar_warn_idx | output | 1 | Clock index of the faulty nibble within its turnaround |
| tar_warn_second | output | 1 | 1 if the fault was in the closing turnaround |
| sync_err | output | 1 | One-clock strobe: unknown sync code, transfer dropped |

## Verification
The embedded properties assume that LAD and the frame strobe are always known values and change only between rising edges. They also assume that every frame-low stretch is followed by a high clock carrying a kind nibble. The bench meets these assumptions by driving both lines on the falling edge and always issuing two start clocks before raising the frame strobe. Aborts, back-to-back transfers and wait states stay on nibble boundaries, so the properties on counter bounds and state returns see only legal field sequences.

// File: rtl/lpc_mon_pkg.sv
`timescale 1ns/1ps
// Shared types and field codes for the bus cycle monitor.
// Assumes a 4-bit LAD nibble; codes are fixed by the bus protocol.
package lpc_mon_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_ADDR,
        ST_TAR1,
        ST_SYNC,
        ST_DATA,
        ST_TAR2
    } mon_state_e;

    localparam logic [3:0] NIB_HOST_START = 4'b0000;
    localparam logic [3:0] NIB_SYNC_READY = 4'b0000;
    localparam logic [3:0] NIB_SYNC_SHORT = 4'b0101;
    localparam logic [3:0] NIB_SYNC_LONG  = 4'b0110;
    localparam logic [3:0] NIB_TAR_IDLE   = 4'b1111;

endpackage

// File: rtl/lpc_mon_seq.sv
`timescale 1ns/1ps
// Field sequencer: walks start, kind, address, turnaround, sync, data and
// closing turnaround, and issues per-field strobes with a shared index.
// Assumes inputs are sampled on the rising clock edge and are never X.
module lpc_mon_seq
    import lpc_mon_pkg::*;
#(
    parameter int MEM_NIBBLES  = 8,
    parameter int IO_NIBBLES   = 4,
    parameter int TAR_CLKS     = 2,
    parameter int DATA_NIBBLES = 2,
    parameter int CNT_W        = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_n,
    input  logic [3:0]       lad,
    output logic [CNT_W-1:0] idx_o,
    output logic             hdr_ok_o,
    output logic             addr_en_o,
    output logic             data_en_o,
    output logic             tar_en_o,
    output logic             in_tar2_o,
    output logic             done_o,
    output logic             sync_fail_o,
    output logic             is_mem_o,
    output logic             write_o
);

    localparam logic [CNT_W-1:0] MEM_LAST  = CNT_W'(MEM_NIBBLES - 1);
    localparam logic [CNT_W-1:0] IO_LAST   = CNT_W'(IO_NIBBLES - 1);
    localparam logic [CNT_W-1:0] TAR_LAST  = CNT_W'(TAR_CLKS - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_NIBBLES - 1);

    mon_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [3:0]       start_q;
    logic             is_mem_q, write_q;
    logic [CNT_W-1:0] addr_last;
    logic             hdr_ok, addr_en, data_en, tar_en, done, sync_fail;

    // Last address index depends on the latched transfer kind.
    assign addr_last = is_mem_q ? MEM_LAST : IO_LAST;

    // Next-state and strobe decode for the current field.
    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        hdr_ok    = 1'b0;
        addr_en   = 1'b0;
        data_en   = 1'b0;
        tar_en    = 1'b0;
        done      = 1'b0;
        sync_fail = 1'b0;
        if (!frame_n && state_q != ST_IDLE && state_q != ST_START) begin
            state_d = ST_START;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (!frame_n) begin
                        state_d = ST_START;
                    end
                end
                ST_START: begin
                    if (frame_n) begin
                        if (start_q == NIB_HOST_START && lad[3] == 1'b0) begin
                            hdr_ok  = 1'b1;
                            state_d = ST_ADDR;
                            cnt_d   = '0;
                        end else begin
                            state_d = ST_IDLE;
                        end
                    end
                end
                ST_ADDR: begin
                    addr_en = 1'b1;
                    if (cnt_q == addr_last) begin
                        state_d = ST_TAR1;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_TAR1: begin
                    tar_en = 1'b1;
                    if (cnt_q == TAR_LAST) begin
                        state_d = ST_SYNC;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_SYNC: begin
                    if (lad == NIB_SYNC_READY) begin
                        state_d = ST_DATA;
                        cnt_d   = '0;
                    end else if (lad != NIB_SYNC_SHORT && lad != NIB_SYNC_LONG) begin
                        sync_fail = 1'b1;
                        state_d   = ST_IDLE;
                        cnt_d     = '0;
                    end
                end
                ST_DATA: begin
                    data_en = 1'b1;
                    if (cnt_q == DATA_LAST) begin
                        state_d = ST_TAR2;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_TAR2: begin
                    tar_en = 1'b1;
                    if (cnt_q == TAR_LAST) begin
                        done    = 1'b1;
                        state_d = ST_IDLE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // State, index, start nibble and header latch registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            start_q  <= NIB_TAR_IDLE;
            is_mem_q <= 1'b0;
            write_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (!frame_n) begin
                start_q <= lad;
            end
            if (hdr_ok) begin
                is_mem_q <= lad[2];
                write_q  <= lad[1];
            end
        end
    end

    assign idx_o       = cnt_q;
    assign hdr_ok_o    = hdr_ok;
    assign addr_en_o   = addr_en;
    assign data_en_o   = data_en;
    assign tar_en_o    = tar_en;
    assign in_tar2_o   = (state_q == ST_TAR2);
    assign done_o      = done;
    assign sync_fail_o = sync_fail;
    assign is_mem_o    = is_mem_q;
    assign write_o     = write_q;

    AST_HDR_TO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_ok |=> (state_q == ST_ADDR && cnt_q == '0)); // R3
    AST_ADDR_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADDR) |-> (cnt_q <= addr_last)); // R4
    AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (state_q == ST_IDLE)); // R11
    AST_SYNC_FAIL_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        sync_fail |=> (state_q == ST_IDLE)); // R8
    AST_ABORT_TO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_n && state_q != ST_IDLE) |=> (state_q == ST_START)); // R12

endmodule

// File: rtl/lpc_mon_addr.sv
`timescale 1ns/1ps
// Address assembler: places each address nibble most significant first,
// with the position taken from the transfer kind's nibble count.
// Assumes idx counts up from zero while en is high.
module lpc_mon_addr #(
    parameter int MEM_NIBBLES = 8,
    parameter int IO_NIBBLES  = 4,
    parameter int CNT_W       = 3,
    parameter int ADDR_W      = 4 * MEM_NIBBLES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic              is_mem,
    input  logic [CNT_W-1:0]  idx,
    input  logic [3:0]        lad,
    output logic [ADDR_W-1:0] addr_o
);

    logic [CNT_W-1:0] pos;

    // Nibble slot for the incoming nibble, counted from the bottom.
    assign pos = (is_mem ? CNT_W'(MEM_NIBBLES - 1) : CNT_W'(IO_NIBBLES - 1)) - idx;

    for (genvar k = 0; k < MEM_NIBBLES; k++) begin : g_nib
        // One nibble slot of the address.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                addr_o[k*4 +: 4] <= 4'h0;
            end else if (en && pos == CNT_W'(k)) begin
                addr_o[k*4 +: 4] <= lad;
            end
        end
    end

    AST_IO_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !is_mem) |-> (idx < CNT_W'(IO_NIBBLES))); // R5

endmodule

// File: rtl/lpc_mon_data.sv
`timescale 1ns/1ps
// Data assembler: places data nibbles least significant first.
// Assumes idx counts up from zero while en is high.
module lpc_mon_data #(
    parameter int DATA_NIBBLES = 2,
    parameter int CNT_W        = 3,
    parameter int DATA_W       = 4 * DATA_NIBBLES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic [CNT_W-1:0]  idx,
    input  logic [3:0]        lad,
    output logic [DATA_W-1:0] data_o
);

    for (genvar k = 0; k < DATA_NIBBLES; k++) begin : g_nib
        // One nibble slot of the data byte.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                data_o[k*4 +: 4] <= 4'h0;
            end else if (en && idx == CNT_W'(k)) begin
                data_o[k*4 +: 4] <= lad;
            end
        end
    end

    AST_DATA_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (idx < CNT_W'(DATA_NIBBLES))); // R9

endmodule

// File: rtl/lpc_mon_tar.sv
`timescale 1ns/1ps
// Turnaround checker: flags any turnaround nibble that is not all ones
// and records the nibble, its clock index and which turnaround it was.
// Assumes en is high only during turnaround clocks.
module lpc_mon_tar
    import lpc_mon_pkg::*;
#(
    parameter int IDX_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             second,
    input  logic [IDX_W-1:0] idx,
    input  logic [3:0]       lad,
    output logic             warn_o,
    output logic [3:0]       nib_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             second_o
);

    logic bad;

    // A turnaround clock with a nibble other than idle.
    assign bad = en && (lad != NIB_TAR_IDLE);

    // Warning pulse and its held detail fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warn_o   <= 1'b0;
            nib_o    <= 4'h0;
            idx_o    <= '0;
            second_o <= 1'b0;
        end else begin
            warn_o <= bad;
            if (bad) begin
                nib_o    <= lad;
                idx_o    <= idx;
                second_o <= second;
            end
        end
    end

    AST_WARN_AFTER_TAR: assert property (@(posedge clk) disable iff (!rst_n)
        warn_o |-> $past(en)); // R6

endmodule

// File: rtl/lpc_cycle_mon.sv
`timescale 1ns/1ps
// Passive bus cycle monitor top: ties the sequencer to the address, data
// and turnaround units and registers the completed-transfer report.
// Assumes it only observes the bus; it never drives LAD or the strobe.
module lpc_cycle_mon #(
    parameter int MEM_NIBBLES  = 8,
    parameter int IO_NIBBLES   = 4,
    parameter int TAR_CLKS     = 2,
    parameter int DATA_NIBBLES = 2,
    localparam int ADDR_W      = 4 * MEM_NIBBLES,
    localparam int IO_ADDR_W   = 4 * IO_NIBBLES,
    localparam int DATA_W      = 4 * DATA_NIBBLES,
    localparam int TAR_IDX_W   = (TAR_CLKS > 1) ? $clog2(TAR_CLKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_n,
    input  logic [3:0]           lad,
    output logic                 cycle_valid,
    output logic                 cycle_is_mem,
    output logic                 cycle_write,
    output logic [ADDR_W-1:0]    cycle_addr,
    output logic [DATA_W-1:0]    cycle_data,
    output logic                 tar_warn,
    output logic [3:0]           tar_warn_nib,
    output logic [TAR_IDX_W-1:0] tar_warn_idx,
    output logic                 tar_warn_second,
    output logic                 sync_err
);

    localparam int MAX_A = (MEM_NIBBLES > IO_NIBBLES) ? MEM_NIBBLES : IO_NIBBLES;
    localparam int MAX_B = (TAR_CLKS > DATA_NIBBLES) ? TAR_CLKS : DATA_NIBBLES;
    localparam int MAX_N = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W = (MAX_N > 1) ? $clog2(MAX_N) : 1;

    logic [CNT_W-1:0]  idx;
    logic              hdr_ok, addr_en, data_en, tar_en, in_tar2;
    logic              done, sync_fail, is_mem, write;
    logic [ADDR_W-1:0] addr_asm;
    logic [DATA_W-1:0] data_asm;

    lpc_mon_seq #(
        .MEM_NIBBLES (MEM_NIBBLES),
        .IO_NIBBLES  (IO_NIBBLES),
        .TAR_CLKS    (TAR_CLKS),
        .DATA_NIBBLES(DATA_NIBBLES),
        .CNT_W       (CNT_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_n    (frame_n),
        .lad        (lad),
        .idx_o      (idx),
        .hdr_ok_o   (hdr_ok),
        .addr_en_o  (addr_en),
        .data_en_o  (data_en),
        .tar_en_o   (tar_en),
        .in_tar2_o  (in_tar2),
        .done_o     (done),
        .sync_fail_o(sync_fail),
        .is_mem_o   (is_mem),
        .write_o    (write)
    );

    lpc_mon_addr #(
        .MEM_NIBBLES(MEM_NIBBLES),
        .IO_NIBBLES (IO_NIBBLES),
        .CNT_W      (CNT_W),
        .ADDR_W     (ADDR_W)
    ) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (hdr_ok),
        .en    (addr_en),
        .is_mem(is_mem),
        .idx   (idx),
        .lad   (lad),
        .addr_o(addr_asm)
    );

    lpc_mon_data #(
        .DATA_NIBBLES(DATA_NIBBLES),
        .CNT_W       (CNT_W),
        .DATA_W      (DATA_W)
    ) u_data (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (hdr_ok),
        .en    (data_en),
        .idx   (idx),
        .lad   (lad),
        .data_o(data_asm)
    );

    lpc_mon_tar #(
        .IDX_W(TAR_IDX_W)
    ) u_tar (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (tar_en),
        .second  (in_tar2),
        .idx     (idx[TAR_IDX_W-1:0]),
        .lad     (lad),
        .warn_o  (tar_warn),
        .nib_o   (tar_warn_nib),
        .idx_o   (tar_warn_idx),
        .second_o(tar_warn_second)
    );

    // Completed-transfer report and sync error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cycle_valid  <= 1'b0;
            cycle_is_mem <= 1'b0;
            cycle_write  <= 1'b0;
            cycle_addr   <= '0;
            cycle_data   <= '0;
            sync_err     <= 1'b0;
        end else begin
            cycle_valid <= done;
            sync_err    <= sync_fail;
            if (done) begin
                cycle_is_mem <= is_mem;
                cycle_write  <= write;
                cycle_addr   <= addr_asm;
                cycle_data   <= data_asm;
            end
        end
    end

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_valid |=> !cycle_valid); // R10
    AST_IO_ADDR_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_valid && !cycle_is_mem) |-> (cycle_addr[ADDR_W-1:IO_ADDR_W] == '0)); // R5
    AST_ERR_NOT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err |-> !cycle_valid); // R8
    AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !cycle_valid |-> ($stable(cycle_addr) && $stable(cycle_data))); // R10

endmodule

// File: tb/lpc_cycle_mon_tb.sv
`timescale 1ns/1ps
module lpc_cycle_mon_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_n = 1'b1;
    logic [3:0]  lad = 4'hF;
    logic        cycle_valid, cycle_is_mem, cycle_write;
    logic [31:0] cycle_addr;
    logic [7:0]  cycle_data;
    logic        tar_warn, tar_warn_idx, tar_warn_second, sync_err;
    logic [3:0]  tar_warn_nib;

    lpc_cycle_mon u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .frame_n        (frame_n),
        .lad            (lad),
        .cycle_valid    (cycle_valid),
        .cycle_is_mem   (cycle_is_mem),
        .cycle_write    (cycle_write),
        .cycle_addr     (cycle_addr),
        .cycle_data     (cycle_data),
        .tar_warn       (tar_warn),
        .tar_warn_nib   (tar_warn_nib),
        .tar_warn_idx   (tar_warn_idx),
        .tar_warn_second(tar_warn_second),
        .sync_err       (sync_err)
    );

    always #10 clk = ~clk;

    typedef struct {
        int          at;
        logic [31:0] a;
        logic [7:0]  d;
        logic        w;
        logic        m;
        string       tag;
    } vexp_t;

    typedef struct {
        int         at;
        logic [3:0] nib;
        logic       idx;
        logic       second;
    } wexp_t;

    vexp_t vq[$];
    wexp_t wq[$];
    int    eq[$];
    vexp_t cur_v;
    wexp_t cur_w;

    int    cyc = 0;
    int    p_last = 0;
    int    n_chk = 0;
    int    n_err = 0;
    bit    chk_on = 1'b0;
    bit    finished = 1'b0;
    string tag = "R1";
    logic [31:0] last_a = '0;
    logic [7:0]  last_d = '0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h (clock %0d)", req, what, act, exp, cyc);
        end
    endtask

    // Reference comparison on every clock, away from the sampling edge.
    always @(negedge clk) begin
        if (chk_on && !finished) begin
            if (vq.size() > 0 && vq[0].at == cyc) begin
                cur_v = vq.pop_front();
                check(cur_v.tag, "cycle_valid", 32'(cycle_valid), 32'd1);
                check(cur_v.tag, "cycle_addr", cycle_addr, cur_v.a);
                check(cur_v.tag, "cycle_data", 32'(cycle_data), 32'(cur_v.d));
                check(cur_v.tag, "cycle_write", 32'(cycle_write), 32'(cur_v.w));
                check(cur_v.tag, "cycle_is_mem", 32'(cycle_is_mem), 32'(cur_v.m));
            end else begin
                check(tag, "cycle_valid idle", 32'(cycle_valid), 32'd0);
            end
            if (wq.size() > 0 && wq[0].at == cyc) begin
                cur_w = wq.pop_front();
                check("R6", "tar_warn", 32'(tar_warn), 32'd1);
                check("R6", "tar_warn_nib", 32'(tar_warn_nib), 32'(cur_w.nib));
                check("R6", "tar_warn_idx", 32'(tar_warn_idx), 32'(cur_w.idx));
                check("R6", "tar_warn_second", 32'(tar_warn_second), 32'(cur_w.second));
            end else begin
                check("R6", "tar_warn idle", 32'(tar_warn), 32'd0);
            end
            if (eq.size() > 0 && eq[0] == cyc) begin
                void'(eq.pop_front());
                check("R8", "sync_err", 32'(sync_err), 32'd1);
            end else begin
                check("R8", "sync_err idle", 32'(sync_err), 32'd0);
            end
        end
    end

    task automatic drive(input logic f, input logic [3:0] l);
        @(negedge clk);
        frame_n = f;
        lad     = l;
        p_last  = cyc + 1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b1, 4'hF);
    endtask

    task automatic push_warn(input logic [3:0] nib, input logic idx, input logic second);
        wexp_t e;
        e.at = p_last; e.nib = nib; e.idx = idx; e.second = second;
        wq.push_back(e);
    endtask

    task automatic do_cycle(input string t, input logic [3:0] s0, input logic [3:0] s1,
                            input logic [3:0] ct, input logic [31:0] a, input logic [7:0] d,
                            input int waits, input logic [3:0] sy,
                            input logic [3:0] t0, input logic [3:0] t1,
                            input logic [3:0] t2, input logic [3:0] t3);
        bit ok;
        int n;
        vexp_t e;
        ok  = (s1 == 4'h0) && (ct[3] == 1'b0);
        n   = ct[2] ? 8 : 4;
        tag = t;
        drive(1'b0, s0);
        drive(1'b0, s1);
        drive(1'b1, ct);
        for (int i = n - 1; i >= 0; i--) drive(1'b1, a[i*4 +: 4]);
        drive(1'b1, t0); if (ok && t0 != 4'hF) push_warn(t0, 1'b0, 1'b0);
        drive(1'b1, t1); if (ok && t1 != 4'hF) push_warn(t1, 1'b1, 1'b0);
        for (int i = 0; i < waits; i++) drive(1'b1, (i % 2 == 1) ? 4'h6 : 4'h5);
        drive(1'b1, sy);
        if (sy != 4'h0) begin
            if (ok) eq.push_back(p_last);
            return;
        end
        drive(1'b1, d[3:0]);
        drive(1'b1, d[7:4]);
        drive(1'b1, t2); if (ok && t2 != 4'hF) push_warn(t2, 1'b0, 1'b1);
        drive(1'b1, t3); if (ok && t3 != 4'hF) push_warn(t3, 1'b1, 1'b1);
        if (ok) begin
            e.at = p_last;
            e.a  = (n == 8) ? a : {16'h0, a[15:0]};
            e.d  = d;
            e.w  = ct[1];
            e.m  = ct[2];
            e.tag = t;
            vq.push_back(e);
            last_a = e.a;
            last_d = d;
        end
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state of every output
        check("R1", "cycle_valid", 32'(cycle_valid), 32'd0);
        check("R1", "cycle_addr", cycle_addr, 32'd0);
        check("R1", "cycle_data", 32'(cycle_data), 32'd0);
        check("R1", "flags", 32'({cycle_is_mem, cycle_write, tar_warn, tar_warn_idx,
                                   tar_warn_second, sync_err}), 32'd0);
        check("R1", "tar_warn_nib", 32'(tar_warn_nib), 32'd0);
        rst_n  = 1'b1;
        chk_on = 1'b1;
        idle(2);

        // R4: memory read, 32-bit address most significant nibble first
        do_cycle("R4", 4'h0, 4'h0, 4'b0100, 32'h1234_ABCD, 8'h5A, 0, 4'h0,
                 4'hF, 4'hF, 4'hF, 4'hF);
        idle(3);
        // R10: fields held after the strobe
        check("R10", "held addr", cycle_addr, last_a);
        check("R10", "held data", 32'(cycle_data), 32'(last_d));

        // R5: I/O write with wait states (R7)
        do_cycle("R5", 4'h0, 4'h0, 4'b0010, 32'hFFFF_BEEF, 8'hA5, 2, 4'h0,
                 4'hF, 4'hF, 4'hF, 4'hF);
        idle(2);
        // R9: memory write, data least significant nibble first
        do_cycle("R9", 4'h0, 4'h0, 4'b0110, 32'h8000_0001, 8'h3C, 0, 4'h0,
                 4'hF, 4'hF, 4'hF, 4'hF);
        idle(2);
        // R7: long wait chain on an I/O read
        do_cycle("R7", 4'h0, 4'h0, 4'b0000, 32'h0000_0080, 8'hE1, 5, 4'h0,
                 4'hF, 4'hF, 4'hF, 4'hF);
        idle(2);
        // R6: bad turnaround nibbles do not stop decoding
        do_cycle("R6", 4'h0, 4'h0, 4'b0100, 32'hCAFE_0042, 8'h96, 0, 4'h0,
                 4'h7, 4'hF, 4'hF, 4'h0);
        idle(2);
        // R8: unknown sync code drops the transfer
        do_cycle("R8", 4'h0, 4'h0, 4'b0100, 32'h0000_1000, 8'h11, 1, 4'h9,
                 4'hF, 4'hF, 4'hF, 4'hF);
        idle(6);
        // R2: last start nibble not 0000, transfer ignored
        do_cycle("R2", 4'h0, 4'h2, 4'b0100, 32'h5555_5555, 8'h77, 0, 4'h0,
                 4'hF, 4'hF, 4'hF, 4'hF);
        idle(2);
        // R2: first start nibble is a different value, last is 0000: accepted
        do_cycle("R2", 4'h3, 4'h0, 4'b0000, 32'h0000_1F2E, 8'h4D, 0, 4'h0,
                 4'hF, 4'hF, 4'hF, 4'hF);
        idle(2);
        // R3: kind nibble with bit 3 set is ignored
        do_cycle("R3", 4'h0, 4'h0, 4'b1000, 32'h0000_2222, 8'h33, 0, 4'h0,
                 4'hF, 4'hF, 4'hF, 4'hF);
        idle(2);
        // R11: two transfers with no idle clock between them
        do_cycle("R11", 4'h0, 4'h0, 4'b0010, 32'h0000_0A0B, 8'hC3, 0, 4'h0,
                 4'hF, 4'hF, 4'hF, 4'hF);
        do_cycle("R11", 4'h0, 4'h0, 4'b0100, 32'hFEDC_BA98, 8'h21, 0, 4'h0,
                 4'hF, 4'hF, 4'hF, 4'hF);
        idle(2);
        // R12: frame strobe falls mid-address; the new transfer wins
        tag = "R12";
        drive(1'b0, 4'h0);
        drive(1'b0, 4'h0);
        drive(1'b1, 4'b0100);
        drive(1'b1, 4'h9);
        drive(1'b1, 4'h9);
        do_cycle("R12", 4'hF, 4'h0, 4'b0110, 32'h0BAD_F00D, 8'h69, 0, 4'h0,
                 4'hF, 4'hF, 4'hF, 4'hF);
        idle(4);

        check("R10", "pending valid events", 32'(vq.size()), 32'd0);
        check("R6", "pending warn events", 32'(wq.size()), 32'd0);
        check("R8", "pending error events", 32'(eq.size()), 32'd0);
        finish_run();
    end

endmodule